// File: doc/BRIEF.md
# Receive DMA Frame-to-Buffer Writer

This block drains received frame bytes from a receive FIFO and stores them in memory buffers handed out through a ring of receive descriptors. It assembles bytes into a 32-byte line register and commits each line as one aligned burst. When the current buffer fills before the frame ends, the block closes that descriptor and fetches the next one. A single frame can therefore occupy several buffers. Each closed descriptor gets a write-back record: the ownership bit is returned to software, together with a two-bit position code and the count of frame bytes held in that buffer.

The block can insert 0 to 3 filler bytes into the buffer stream at a configured frame offset. An offset of zero places the filler ahead of the frame, so the payload can start at any byte offset. A non-zero offset places the filler inside the frame. Software chooses the offset and the filler length so that the data after the filler starts on a 4-byte boundary. Both settings are latched once per frame.

If the next descriptor is still owned by software when buffer space is needed, the block waits. It keeps polling that descriptor and raises a flag until the descriptor is armed again.

Top module: `rx_dma_writer`

## Requirements
- R1: While reset is asserted, `fifo_ready_o`, `desc_req_o`, `mem_wr_o`, `wb_valid_o` and `desc_empty_o` are all low, and the ring pointer starts at `ring_base_i`.
- R2: Memory writes are 32-byte bursts whose address is a multiple of 32. Successive bursts into one buffer go to the buffer address plus 32·k. A burst holds its address and data until `mem_ready_i` accepts it. A buffer piece of n stream bytes costs ceil(n/32) bursts.
- R3: Without filler, frame byte i is stored at byte offset i of the buffer stream. Buffer bytes beyond the frame end are unspecified.
- R4: With filler offset 0 and filler length p, frame byte i lands at stream offset i+p.
- R5: With filler offset q (0 < q < frame length) and length p, frame bytes below q stay in place and frame byte i ≥ q lands at stream offset i+p. When q is not below the frame length, no filler is inserted.
- R6: The buffer stream is spread over consecutive descriptors, each filled to its buffer length before the next is used. The write-back position code is {first, last}: 2'b11 whole frame, 2'b10 first part, 2'b00 middle part, 2'b01 last part.
- R7: Each write-back (`wb_valid_o`, a one-cycle pulse) reports in `wb_count_o` the number of frame bytes stored in that buffer, excluding filler.
- R8: A descriptor fetched with `desc_active_i` low is not used. `desc_empty_o` goes high and the same descriptor address is requested again. No FIFO byte is taken and no burst is issued until an active descriptor arrives, which clears `desc_empty_o`.
- R9: Descriptor addresses advance by 16 bytes. After a descriptor fetched with `desc_ring_end_i` high, the next address is `ring_base_i`.
- R10: `pad_len_i` and `pad_pos_i` are sampled when a frame starts. Changes during the frame have no effect on its layout.
- R11: When the last frame byte fills the last byte of a buffer, exactly one write-back, with last set, closes the frame, and no further descriptor is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_base_i | input | AW | Address of the first descriptor in the ring |
| pad_len_i | input | 2 | Filler byte count for the next frame |
| pad_pos_i | input | FCW | Frame byte offset where filler is inserted |
| fifo_valid_i | input | 1 | FIFO has a byte |
| fifo_data_i | input | 8 | FIFO byte |
| fifo_last_i | input | 1 | Byte is the final byte of its frame |
| fifo_ready_o | output | 1 | Byte is taken this cycle when valid |
| desc_req_o | output | 1 | Descriptor fetch request |
| desc_addr_o | output | AW | Address of the descriptor being fetched |
| desc_ack_i | input | 1 | Descriptor fields are valid |
| desc_active_i | input | 1 | Descriptor is owned by the block |
| desc_ring_end_i | input | 1 | Descriptor is the last in the ring |
| desc_buf_addr_i | input | AW | Buffer start address, 32-byte aligned |
| desc_buf_len_i | input | LEN_W | Buffer size in bytes, a multiple of 32 |
| desc_empty_o | output | 1 | Waiting on a descriptor owned by software |
| mem_wr_o | output | 1 | Burst write request |
| mem_addr_o | output | AW | Burst address |
| mem_data_o | output | 8·LINE_BYTES | Burst data, byte k in bits 8k+7:8k |
| mem_ready_i | input | 1 | Burst accepted |
| wb_valid_o | output | 1 | Descriptor write-back pulse, ownership returned |
| wb_addr_o | output | AW | Address of the descriptor being closed |
| wb_pos_o | output | 2 | Frame position code |
| wb_count_o | output | LEN_W | Frame bytes stored in the buffer |

## Verification
The bench targets the cycle where two endings coincide: the frame's final byte also fills the final line of a buffer. The line flush then triggers both the buffer-full and the frame-end decisions. A faulty design could close that buffer as a middle part and fetch a useless descriptor, or issue a second write-back. Lengths plus filler that land exactly on 64 and 128 bytes provoke this. The bench judges the outcome by the number of write-backs, the last piece's position code and count, and a check that the descriptor request stays low afterwards. The sweep also runs filler lengths at head and mid-frame offsets, with the memory accepting at once or stalling, so that filler insertion meets line and buffer boundaries.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_FILL,
    S_FLUSH,
    S_WB
  } wr_state_e;

  // write-back position code = {first, last}
  localparam logic [1:0] POS_WHOLE  = 2'b11;
  localparam logic [1:0] POS_FIRST  = 2'b10;
  localparam logic [1:0] POS_MIDDLE = 2'b00;
  localparam logic [1:0] POS_LAST   = 2'b01;
endpackage

// File: rtl/rxdma_line_pack.sv
module rxdma_line_pack #(
  parameter int LINE_BYTES = 32,
  localparam int IDXW = $clog2(LINE_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    we_i,
  input  logic [IDXW-1:0]         idx_i,
  input  logic [7:0]              byte_i,
  output logic [8*LINE_BYTES-1:0] line_o
);
  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_q <= '0;
      else if (clr_i) lane_q <= '0;
      else if (we_i && idx_i == IDXW'(g)) lane_q <= byte_i;
    end
    assign line_o[8*g +: 8] = lane_q;
  end
endmodule

// File: rtl/rxdma_ring_ptr.sv
module rxdma_ring_ptr #(
  parameter int AW = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_q <= '0;
    else if (adv_i) off_q <= wrap_i ? '0 : off_q + AW'(DESC_BYTES);
  end

  assign ptr_o = base_i + off_q;

  a_r9_wrap_to_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && wrap_i && $stable(base_i)) |=> (ptr_o == base_i));
  a_r9_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wrap_i && $stable(base_i)) |=> (ptr_o == $past(ptr_o) + AW'(DESC_BYTES)));
endmodule

// File: rtl/rx_dma_writer.sv
module rx_dma_writer
  import rxdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LEN_W = 16,
  parameter int FCW = 16,
  parameter int LINE_BYTES = 32,
  parameter int DESC_BYTES = 16,
  localparam int IDXW = $clog2(LINE_BYTES),
  localparam int LDW = 8 * LINE_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    ring_base_i,
  input  logic [1:0]       pad_len_i,
  input  logic [FCW-1:0]   pad_pos_i,
  input  logic             fifo_valid_i,
  input  logic [7:0]       fifo_data_i,
  input  logic             fifo_last_i,
  output logic             fifo_ready_o,
  output logic             desc_req_o,
  output logic [AW-1:0]    desc_addr_o,
  input  logic             desc_ack_i,
  input  logic             desc_active_i,
  input  logic             desc_ring_end_i,
  input  logic [AW-1:0]    desc_buf_addr_i,
  input  logic [LEN_W-1:0] desc_buf_len_i,
  output logic             desc_empty_o,
  output logic             mem_wr_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [LDW-1:0]   mem_data_o,
  input  logic             mem_ready_i,
  output logic             wb_valid_o,
  output logic [AW-1:0]    wb_addr_o,
  output logic [1:0]       wb_pos_o,
  output logic [LEN_W-1:0] wb_count_o
);
  localparam logic [LEN_W-1:0] LINE_LEN = LEN_W'(LINE_BYTES);

  wr_state_e        state_q;
  logic [FCW-1:0]   frame_cnt_q, pad_pos_q;
  logic [1:0]       pad_left_q;
  logic [AW-1:0]    buf_addr_q;
  logic [LEN_W-1:0] buf_len_q, buf_used_q, desc_cnt_q;
  logic [IDXW-1:0]  line_idx_q;
  logic             first_q, done_q, ring_end_q, empty_q;
  logic [AW-1:0]    ptr;

  logic pad_now, take, byte_we, line_end, flush_ok, buf_full, frame_end;

  assign pad_now   = (state_q == S_FILL) && (pad_left_q != 2'd0) && (frame_cnt_q == pad_pos_q);
  assign fifo_ready_o = (state_q == S_FILL) && !pad_now;
  assign take      = fifo_ready_o && fifo_valid_i;
  assign byte_we   = pad_now || take;
  assign frame_end = take && fifo_last_i;
  assign line_end  = line_idx_q == IDXW'(LINE_BYTES - 1);
  assign flush_ok  = (state_q == S_FLUSH) && mem_ready_i;
  assign buf_full  = (buf_used_q + LINE_LEN) == buf_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      frame_cnt_q <= '0;
      pad_pos_q   <= '0;
      pad_left_q  <= '0;
      buf_addr_q  <= '0;
      buf_len_q   <= '0;
      buf_used_q  <= '0;
      desc_cnt_q  <= '0;
      line_idx_q  <= '0;
      first_q     <= 1'b0;
      done_q      <= 1'b0;
      ring_end_q  <= 1'b0;
      empty_q     <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (fifo_valid_i) begin
          pad_left_q  <= pad_len_i;
          pad_pos_q   <= pad_pos_i;
          frame_cnt_q <= '0;
          first_q     <= 1'b1;
          done_q      <= 1'b0;
          state_q     <= S_FETCH;
        end
        S_FETCH: if (desc_ack_i) begin
          if (desc_active_i) begin
            buf_addr_q <= desc_buf_addr_i;
            buf_len_q  <= desc_buf_len_i;
            ring_end_q <= desc_ring_end_i;
            buf_used_q <= '0;
            desc_cnt_q <= '0;
            line_idx_q <= '0;
            empty_q    <= 1'b0;
            state_q    <= S_FILL;
          end else begin
            empty_q <= 1'b1;
          end
        end
        S_FILL: if (byte_we) begin
          line_idx_q <= line_idx_q + 1'b1;
          if (pad_now) pad_left_q <= pad_left_q - 2'd1;
          if (take) begin
            frame_cnt_q <= frame_cnt_q + 1'b1;
            desc_cnt_q  <= desc_cnt_q + 1'b1;
          end
          if (frame_end) done_q <= 1'b1;
          if (line_end || frame_end) state_q <= S_FLUSH;
        end
        S_FLUSH: if (mem_ready_i) begin
          buf_used_q <= buf_used_q + LINE_LEN;
          line_idx_q <= '0;
          state_q    <= (done_q || buf_full) ? S_WB : S_FILL;
        end
        S_WB: begin
          first_q <= 1'b0;
          state_q <= done_q ? S_IDLE : S_FETCH;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  rxdma_line_pack #(.LINE_BYTES(LINE_BYTES)) u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (flush_ok),
    .we_i   (byte_we),
    .idx_i  (line_idx_q),
    .byte_i (pad_now ? 8'h00 : fifo_data_i),
    .line_o (mem_data_o)
  );

  rxdma_ring_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .base_i (ring_base_i),
    .adv_i  (state_q == S_WB),
    .wrap_i (ring_end_q),
    .ptr_o  (ptr)
  );

  assign desc_req_o   = state_q == S_FETCH;
  assign desc_addr_o  = ptr;
  assign desc_empty_o = empty_q;
  assign mem_wr_o     = state_q == S_FLUSH;
  assign mem_addr_o   = buf_addr_q + AW'(buf_used_q);
  assign wb_valid_o   = state_q == S_WB;
  assign wb_addr_o    = ptr;
  assign wb_pos_o     = {first_q, done_q};
  assign wb_count_o   = desc_cnt_q;

  a_r2_burst_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_addr_o[IDXW-1:0] == '0));
  a_r2_burst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && !mem_ready_i) |=> (mem_wr_o && $stable(mem_addr_o) && $stable(mem_data_o)));
  a_r7_wb_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> !wb_valid_o);
  a_r8_empty_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_empty_o |-> (desc_req_o && !mem_wr_o && !fifo_ready_o));
  a_r11_no_fetch_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && wb_pos_o[0]) |=> !desc_req_o);
  a_r2_no_take_in_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> !fifo_ready_o);
endmodule

// File: tb/rx_dma_writer_test.sv
`timescale 1ns/1ps
module rx_dma_writer_test;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int FW = 16;
  localparam logic [AW-1:0] BASE = 32'h100;
  localparam int BUF0 = 32'h400;
  localparam int BLEN = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [1:0] pad_len_i = '0;
  logic [FW-1:0] pad_pos_i = '0;
  logic fifo_valid_i = 1'b0, fifo_last_i = 1'b0;
  logic [7:0] fifo_data_i = '0;
  logic fifo_ready_o, desc_req_o, desc_empty_o, mem_wr_o, wb_valid_o;
  logic [AW-1:0] desc_addr_o, mem_addr_o, wb_addr_o;
  logic desc_ack_i = 1'b0, desc_active_i = 1'b0, desc_ring_end_i = 1'b0;
  logic [AW-1:0] desc_buf_addr_i = '0;
  logic [LW-1:0] desc_buf_len_i = '0, wb_count_o;
  logic [255:0] mem_data_o;
  logic mem_ready_i = 1'b0;
  logic [1:0] wb_pos_o;

  rx_dma_writer uut (
    .clk_i(clk), .rst_ni(rst_n), .ring_base_i(BASE),
    .pad_len_i(pad_len_i), .pad_pos_i(pad_pos_i),
    .fifo_valid_i(fifo_valid_i), .fifo_data_i(fifo_data_i), .fifo_last_i(fifo_last_i),
    .fifo_ready_o(fifo_ready_o),
    .desc_req_o(desc_req_o), .desc_addr_o(desc_addr_o), .desc_ack_i(desc_ack_i),
    .desc_active_i(desc_active_i), .desc_ring_end_i(desc_ring_end_i),
    .desc_buf_addr_i(desc_buf_addr_i), .desc_buf_len_i(desc_buf_len_i),
    .desc_empty_o(desc_empty_o),
    .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .mem_ready_i(mem_ready_i),
    .wb_valid_o(wb_valid_o), .wb_addr_o(wb_addr_o), .wb_pos_o(wb_pos_o),
    .wb_count_o(wb_count_o)
  );

  logic [7:0] mem [0:2047];
  bit act [4];
  int total = 0, bad = 0, cyc = 0;
  int wb_n = 0, wr_n = 0, align_bad = 0, ri = 0, ready_mode = 0;
  logic [AW-1:0] wb_a [8];
  logic [1:0] wb_p [8];
  logic [LW-1:0] wb_c [8];
  logic [7:0] fr [256];

  task automatic check(input bit ok, input string tag, input longint act_v, input longint exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  // memory, descriptor and write-back model, all driven at the falling edge
  always @(negedge clk) begin
    cyc++;
    mem_ready_i = (ready_mode == 0) || (cyc % 5 != 3);
    if (desc_req_o) begin
      int idx;
      idx = int'((desc_addr_o - BASE) >> 4) & 3;
      desc_ack_i = 1'b1;
      desc_active_i = act[idx];
      desc_ring_end_i = (idx == 3);
      desc_buf_addr_i = AW'(BUF0 + idx * 256);
      desc_buf_len_i = LW'(BLEN);
    end else begin
      desc_ack_i = 1'b0;
    end
    if (mem_wr_o && mem_ready_i) begin
      wr_n++;
      if (mem_addr_o[4:0] != 5'd0) align_bad++;
      for (int b = 0; b < 32; b++) mem[(int'(mem_addr_o) + b) & 2047] = mem_data_o[8*b +: 8];
    end
    if (wb_valid_o) begin
      if (wb_n < 8) begin
        wb_a[wb_n] = wb_addr_o;
        wb_p[wb_n] = wb_pos_o;
        wb_c[wb_n] = wb_count_o;
      end
      wb_n++;
      act[int'((wb_addr_o - BASE) >> 4) & 3] = 1'b0;
    end
  end

  task automatic run_frame(input int len, input int pl, input int pp, input int seed, input int hole);
    int s, nd, wr0, mism, lines;
    s = len + ((pp < len) ? pl : 0);
    nd = (s + BLEN - 1) / BLEN;
    wb_n = 0;
    wr0 = wr_n;
    for (int a = BUF0; a < BUF0 + 1024; a++) mem[a] = 'x;
    for (int d = 0; d < 4; d++) act[d] = (d != hole);
    pad_len_i = 2'(pl);
    pad_pos_i = FW'(pp);
    for (int i = 0; i < len; i++) begin
      bit acc;
      fr[i] = 8'((seed + i * 7) & 255);
      fifo_valid_i = 1'b1;
      fifo_data_i = fr[i];
      fifo_last_i = (i == len - 1);
      do begin
        acc = fifo_ready_o;
        @(negedge clk);
      end while (!acc);
      // R10: disturb the configuration once the frame is running
      if (i == 0) begin
        pad_len_i = ~2'(pl);
        pad_pos_i = FW'(pp + 3);
      end
    end
    fifo_valid_i = 1'b0;
    fifo_last_i = 1'b0;
    for (int w = 0; w < 1000 && wb_n < nd; w++) @(negedge clk);
    repeat (10) @(negedge clk);

    check(wb_n == nd, "R6/R11 write-back count", wb_n, nd);
    check(desc_req_o == 1'b0, "R11 no fetch after frame end", desc_req_o, 0);
    lines = 0;
    for (int j = 0; j < nd && j < 8; j++) begin
      int idx, lo, hi, cnt;
      logic [1:0] ep;
      idx = (ri + j) % 4;
      lo = j * BLEN;
      hi = (lo + BLEN < s) ? lo + BLEN : s;
      lines += (hi - lo + 31) / 32;
      cnt = 0;
      for (int k = lo; k < hi; k++) if (!(pp < len && k >= pp && k < pp + pl)) cnt++;
      ep = {j == 0, j == nd - 1};
      check(wb_a[j] == BASE + AW'(16 * idx), "R9 descriptor address", wb_a[j], BASE + 16 * idx);
      check(wb_p[j] == ep, "R6 position code", wb_p[j], ep);
      check(wb_c[j] == LW'(cnt), "R7 byte count", wb_c[j], cnt);
    end
    check(wr_n - wr0 == lines, "R2 burst count", wr_n - wr0, lines);
    mism = 0;
    for (int k = 0; k < s; k++) begin
      int fi, addr;
      if (pp < len && k >= pp && k < pp + pl) continue;
      fi = (pp < len && k >= pp + pl) ? k - pl : k;
      addr = BUF0 + ((ri + k / BLEN) % 4) * 256 + (k % BLEN);
      if (mem[addr] !== fr[fi]) mism++;
    end
    if (pl == 0 || pp >= len) check(mism == 0, "R3/R10 byte layout", mism, 0);
    else if (pp == 0) check(mism == 0, "R4/R10 head filler layout", mism, 0);
    else check(mism == 0, "R5/R10 mid filler layout", mism, 0);
    ri = (ri + nd) % 4;
  endtask

  initial begin
    wait (cyc > 150000);
    check(1'b0, "watchdog", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lens [13] = '{1, 3, 31, 32, 33, 60, 61, 64, 65, 100, 127, 128, 130};
    int fno;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!fifo_ready_o && !desc_req_o && !mem_wr_o && !wb_valid_o && !desc_empty_o,
          "R1 outputs idle in reset",
          {fifo_ready_o, desc_req_o, mem_wr_o, wb_valid_o, desc_empty_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    fno = 0;
    foreach (lens[li]) begin
      for (int pl = 0; pl < 4; pl++) begin
        for (int m = 0; m < 2; m++) begin
          ready_mode = fno % 2;
          run_frame(lens[li], pl, (m == 0) ? 0 : 8 - pl, fno * 37 + 11, -1);
          fno++;
        end
      end
    end

    // R8: second descriptor held by software, then re-armed
    ready_mode = 0;
    begin
      int hole, w0;
      hole = (ri + 1) % 4;
      fork
        run_frame(100, 2, 0, 91, hole);
        begin
          for (int w = 0; w < 500 && !desc_empty_o; w++) @(negedge clk);
          repeat (5) @(negedge clk);
          w0 = wr_n;
          check(desc_empty_o == 1'b1, "R8 empty flag raised", desc_empty_o, 1);
          check(desc_req_o && desc_addr_o == BASE + AW'(16 * hole), "R8 re-polls same descriptor",
                desc_addr_o, BASE + 16 * hole);
          repeat (10) begin
            check(!fifo_ready_o, "R8 no byte taken while stalled", fifo_ready_o, 0);
            @(negedge clk);
          end
          check(wr_n == w0, "R8 no burst while stalled", wr_n - w0, 0);
          act[hole] = 1'b1;
        end
      join
      check(desc_empty_o == 1'b0, "R8 empty flag cleared", desc_empty_o, 0);
    end
    check(align_bad == 0, "R2 burst alignment", align_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule